// File: doc/BRIEF.md
# Dual-Order Self-Test Address Sequencer

This block produces the row and column address for a memory self-test engine. It keeps two counters. The column counter (X) and the row counter (Y) are each sized at run time by a 4-bit width field. The pattern engine starts each march element with a strobe that also selects the counting direction. After that it requests one new address per advance strobe. The block walks the whole array in one of two nestings: the column counter innermost (x-fast) or the row counter innermost (y-fast). It raises an end flag together with the last address of the element.

For bit-line stress patterns, a stress-mode input forces x-fast nesting regardless of the order select. A separate override input replaces the row part of the address with row 0 and leaves the column part unchanged, so the engine can touch the sacrificial first row of the current column without disturbing the sweep position. The block generates and compares no data.

Top module: `ag_top`

## Requirements
- R1: After reset `addrOut` is all zero and `sweepEnd` is low. Advance strobes before the first element start leave the address at zero.
- R2: Each width field gives its counter 1 to 15 bits. A field value of 0 behaves as 1. Output bits above the programmed width stay zero. The column counter sits in `addrOut[14:0]` and the row counter in `addrOut[29:15]`.
- R3: In x-fast order (`yFast`=0) the column counter changes on every accepted advance. The row counter changes only when the column counter wraps.
- R4: In y-fast order (`yFast`=1, `stressMode`=0) the row counter changes on every accepted advance. The column counter changes only when the row counter wraps.
- R5: An element start with `startDown`=0 loads zero into both counters. With `startDown`=1 it loads each counter's all-ones maximum. The loaded address appears in the cycle after the start strobe.
- R6: In a down element every step decrements. An inner counter at zero wraps to its maximum, and the outer counter then decrements.
- R7: `sweepEnd` is high exactly while a started element sits on its last address: all maxima when counting up, all zeros when counting down.
- R8: While `sweepEnd` is high, advance strobes leave the address unchanged until the next element start.
- R9: While `sacRow` is high, the row field of `addrOut` reads zero and the column field shows the current column. The override is combinational and does not change the counters.
- R10: With `stressMode` high the order is x-fast even when `yFast` is 1.
- R11: An element start and an advance in the same cycle act as a start alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xBits | input | 4 | Column counter width field |
| yBits | input | 4 | Row counter width field |
| yFast | input | 1 | 1 selects row-innermost order |
| stressMode | input | 1 | Forces column-innermost order |
| startEl | input | 1 | Element start strobe |
| startDown | input | 1 | Direction for the element being started (1 = down) |
| advance | input | 1 | Step to the next address |
| sacRow | input | 1 | Replace the row field with row 0 |
| addrOut | output | 30 | {row, column} address |
| sweepEnd | output | 1 | Current address is the element's last |

## Verification
A start or advance strobe sampled at one rising edge shows its effect on `addrOut` and `sweepEnd` right after that edge, one register stage later. The row override acts on `addrOut` in the same cycle with no register. The bench drives its inputs at the falling edge and lets one rising edge pass. It updates its step-index model at that rising edge and compares both outputs at the next falling edge, against the override value it is driving at that moment.

// File: rtl/ag_pkg.sv
package ag_pkg;
  typedef struct packed {
    logic load;  // reload both counters
    logic step;  // accepted advance
    logic down;  // direction in force
  } agStrobe_t;
endpackage

// File: rtl/ag_ctrl.sv
module ag_ctrl
  import ag_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startEl,
  input  logic      startDown,
  input  logic      advance,
  input  logic      atEnd,
  output agStrobe_t strb,
  output logic      running
);
  logic dirDown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      dirDown <= 1'b0;
    end else if (startEl) begin
      running <= 1'b1;
      dirDown <= startDown;
    end
  end

  always_comb begin
    strb.load = startEl;
    strb.down = startEl ? startDown : dirDown;
    strb.step = advance && running && !atEnd && !startEl;
  end
endmodule

// File: rtl/ag_path.sv
module ag_path
  import ag_pkg::*;
#(
  parameter int AW = 15,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  agStrobe_t     strb,
  input  logic [FW-1:0] xBits,
  input  logic [FW-1:0] yBits,
  input  logic          xInner,
  input  logic          sacRow,
  output logic [2*AW-1:0] addrOut,
  output logic          atEnd
);
  localparam int AXES = 2;

  logic [FW-1:0] fld   [AXES];
  logic [AW-1:0] lim   [AXES];
  logic [AW-1:0] cnt   [AXES];
  logic [AW-1:0] nxt   [AXES];
  logic [AW-1:0] startV[AXES];
  logic          wrap  [AXES];
  logic          move  [AXES];

  assign fld[0] = xBits;
  assign fld[1] = yBits;

  always_comb begin
    int e;
    for (int i = 0; i < AXES; i++) begin
      e = int'(fld[i]);
      if (e < 1) e = 1;
      if (e > AW) e = AW;
      lim[i]    = {AW{1'b1}} >> (AW - e);
      startV[i] = strb.down ? lim[i] : '0;
      wrap[i]   = (cnt[i] == (strb.down ? '0 : lim[i]));
      nxt[i]    = wrap[i] ? startV[i]
                          : (strb.down ? cnt[i] - 1'b1 : cnt[i] + 1'b1);
    end
    move[0] = strb.step && (xInner || wrap[1]);
    move[1] = strb.step && (!xInner || wrap[0]);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < AXES; i++) begin
      if (!rstN)            cnt[i] <= '0;
      else if (strb.load)   cnt[i] <= startV[i];
      else if (move[i])     cnt[i] <= nxt[i];
    end
  end

  assign atEnd   = wrap[0] && wrap[1];
  assign addrOut = {(sacRow ? {AW{1'b0}} : cnt[1]), cnt[0]};

  // R5: upward start clears both counters
  a_r5_load_up: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && !strb.down |=> (cnt[0] == '0) && (cnt[1] == '0));

  // R5: downward start loads both maxima
  a_r5_load_down: assert property (@(posedge clk) disable iff (!rstN)
    strb.load && strb.down |=> (cnt[0] == $past(lim[0])) && (cnt[1] == $past(lim[1])));

  // R3: row holds while column steps without wrapping
  a_r3_row_waits: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && xInner && !wrap[0] |=> cnt[1] == $past(cnt[1]));

  // R4: column holds while row steps without wrapping
  a_r4_col_waits: assert property (@(posedge clk) disable iff (!rstN)
    strb.step && !xInner && !wrap[1] |=> cnt[0] == $past(cnt[0]));
endmodule

// File: rtl/ag_top.sv
module ag_top
  import ag_pkg::*;
#(
  parameter int AW = 15,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [FW-1:0] xBits,
  input  logic [FW-1:0] yBits,
  input  logic          yFast,
  input  logic          stressMode,
  input  logic          startEl,
  input  logic          startDown,
  input  logic          advance,
  input  logic          sacRow,
  output logic [2*AW-1:0] addrOut,
  output logic          sweepEnd
);
  agStrobe_t strb;
  logic      running;
  logic      atEnd;
  logic      xInner;

  assign xInner = stressMode || !yFast;

  ag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startEl(startEl), .startDown(startDown),
    .advance(advance), .atEnd(atEnd), .strb(strb), .running(running)
  );

  ag_path #(.AW(AW), .FW(FW)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .xBits(xBits), .yBits(yBits),
    .xInner(xInner), .sacRow(sacRow), .addrOut(addrOut), .atEnd(atEnd)
  );

  assign sweepEnd = running && atEnd;

  // R8: end flag persists until a new element starts
  a_r8_end_sticks: assert property (@(posedge clk) disable iff (!rstN)
    sweepEnd && !startEl |=> sweepEnd || startEl);
endmodule

// File: tb/ag_top_tb_top.sv
`timescale 1ns/1ps
module ag_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  xBits = '0, yBits = '0;
  logic        yFast = 1'b0, stressMode = 1'b0;
  logic        startEl = 1'b0, startDown = 1'b0, advance = 1'b0, sacRow = 1'b0;
  logic [29:0] addrOut;
  logic        sweepEnd;

  int nChecks = 0, nFail = 0;
  int k = 0, total = 1, nx = 2, ny = 2;
  bit mRun = 0, mDown = 0, mXin = 1;

  always #2.5 clk = ~clk;

  ag_top dut_i (
    .clk(clk), .rstN(rstN), .xBits(xBits), .yBits(yBits), .yFast(yFast),
    .stressMode(stressMode), .startEl(startEl), .startDown(startDown),
    .advance(advance), .sacRow(sacRow), .addrOut(addrOut), .sweepEnd(sweepEnd)
  );

  function automatic int effBits(int f);
    return (f == 0) ? 1 : f;
  endfunction

  function automatic logic [29:0] expAddr(bit sac);
    int a, b, x, y, inN;
    if (!mRun) return '0;
    inN = mXin ? nx : ny;
    a = k % inN;
    b = k / inN;
    if (mXin) begin x = a; y = b; end else begin y = a; x = b; end
    if (mDown) begin x = nx - 1 - x; y = ny - 1 - y; end
    return {(sac ? 15'd0 : 15'(y)), 15'(x)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit st, bit dn, bit adv, bit sac, string tag = "");
    string t;
    bit wasEnd;
    startEl = st; startDown = dn; advance = adv; sacRow = sac;
    @(posedge clk);
    wasEnd = mRun && (k == total - 1);
    if (st) begin
      mRun = 1; mDown = dn; k = 0;
      mXin = stressMode || !yFast;
      nx = 1 << effBits(int'(xBits));
      ny = 1 << effBits(int'(yBits));
      total = nx * ny;
    end else if (adv && mRun && k != total - 1) begin
      k++;
    end
    @(negedge clk);
    if (tag != "") t = tag;
    else if (wasEnd && adv && !st) t = "R8";
    else if (sac) t = "R9";
    else if (stressMode && yFast) t = "R10";
    else if (mDown) t = "R6";
    else if (mXin) t = "R3";
    else t = "R4";
    chk(t, 32'(addrOut), 32'(expAddr(sac)));
    chk("R7", 32'(sweepEnd), 32'(mRun && (k == total - 1)));
  endtask

  task automatic cfg(int xb, int yb, bit yf, bit sm);
    xBits = 4'(xb); yBits = 4'(yb); yFast = yf; stressMode = sm;
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    chk("R1", 32'(addrOut), 0);
    chk("R1", 32'(sweepEnd), 0);
    cyc(0, 0, 1, 0, "R1");
    cyc(0, 0, 1, 0, "R1");

    // x-fast up, 4x2 array, full sweep then extra advances
    cfg(2, 1, 0, 0);
    cyc(1, 0, 0, 0, "R5");
    for (int i = 0; i < 7; i++) cyc(0, 0, 1, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0);

    // y-fast down, 2x8 array
    cfg(1, 3, 1, 0);
    cyc(1, 1, 0, 0, "R5");
    for (int i = 0; i < 18; i++) cyc(0, 0, 1, 0);

    // stress forces x-fast despite yFast
    cfg(2, 2, 1, 1);
    cyc(1, 0, 0, 0);
    for (int i = 0; i < 17; i++) cyc(0, 0, 1, i[1]);

    // field value 0 acts as 1 bit
    cfg(0, 0, 0, 0);
    cyc(1, 0, 0, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, "R2");

    // full width down start, upper field bits
    cfg(15, 15, 0, 0);
    cyc(1, 1, 0, 0, "R5");
    cyc(0, 0, 1, 0, "R6");
    cyc(0, 0, 1, 1, "R9");
    cfg(15, 3, 0, 0);
    cyc(1, 1, 0, 0, "R2");

    // start and advance together
    cfg(2, 2, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(1, 1, 1, 0, "R11");
    cyc(0, 0, 1, 0);

    // random elements
    for (int e = 0; e < 30; e++) begin
      int guard;
      cfg($urandom_range(0, 4), $urandom_range(0, 4),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0));
      cyc(1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0);
      guard = 0;
      while (k != total - 1 && guard < 2000) begin
        cyc(0, 0, $urandom_range(0, 9) < 7, $urandom_range(0, 4) == 0);
        guard++;
      end
      for (int j = 0; j < 3; j++) cyc(0, 0, 1, 1'($urandom_range(0, 1)));
    end

    finish();
  end
endmodule